// File: doc/BRIEF.md
# Wake Event Status and Enable Controller

This block gathers power-management wake events from a fixed set of board-level sources and records each one in a sticky status bit. Software reads the status to see which source fired and clears bits by writing ones to them. A per-source enable register and a global wake enable decide whether the block pulls down its active-low, open-drain wake request line. Pending system-management events from a neighbouring block can also reach that line, but only through a separate two-bit route.

The sources are two ring-indicator lines, a ring pin, a valid-infrared-frame strobe, the keyboard and mouse clock lines, an RTC alarm and eight general-purpose inputs. Every asynchronous source passes through a two-flop synchroniser followed by an edge detector. A byte-wide synchronous port gives access to status, enable and control. Reads are combinational, so there are no wait states. The pad is modelled as a single pull-low enable. The pad's data value is always 0, so the line is either sunk low or left floating and is never driven high.

Top module: `wake_evt_ctrl`

## Requirements
- R1: While the global wake enable (control bit 0) is 0, `wake_pull` is 0 on every cycle after the one in which the bit was seen clear, whatever status, enable or SMI inputs hold.
- R2: With the global enable at 1, `wake_pull` becomes 1 one cycle after some status bit and its matching enable bit are both 1. It returns to 0 one cycle after no such pair remains and the SMI route is inactive.
- R3: A source's status bit is set by its active transition whether or not any enable is on. An active transition is a falling edge on the ring-indicator, ring, keyboard-clock and mouse-clock lines, and a rising edge on the infrared strobe, the RTC alarm and the general-purpose inputs. The bit is readable on the third rising clock edge after the input changes.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R5: If a set event and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R6: The register map is as follows. Address 0 holds status[7:0] and address 1 holds status[15:8]. Address 2 holds enable[7:0] and address 3 holds enable[15:8]. Address 4 is control: bit0 is the global enable, bit1 the device-interrupt enable and bit2 the SMI route. Other addresses read 0. The status and enable bit positions are: 0–7 general-purpose inputs 0–7, 8 ring indicator 1, 9 ring indicator 2, 10 ring pin, 11 infrared strobe, 12 keyboard clock, 13 mouse clock, 14 RTC alarm, 15 SMI-seen.
- R7: After reset, all status, enable and control bits read 0 and `wake_pull` is 0.
- R8: With the global enable at 1 and any `smi_pend` bit at 1, `wake_pull` is 1 only when both the device-interrupt enable and the SMI route bit are 1.
- R9: Status bit 15 is set on a rising edge of the OR of `smi_pend` and has no enable. Enable bit 15 always reads 0, and status bit 15 never drives `wake_pull` on its own.
- R10: A transition in the inactive direction on any source leaves its status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Standby-power reset, active low, asynchronous |
| ri1_n | input | 1 | Ring indicator 1, asynchronous, active falling |
| ri2_n | input | 1 | Ring indicator 2, asynchronous, active falling |
| ring_n | input | 1 | Ring pin, asynchronous, active falling |
| ir_valid | input | 1 | Valid infrared frame strobe, active rising |
| kb_clk | input | 1 | Keyboard clock line, active falling |
| ms_clk | input | 1 | Mouse clock line, active falling |
| rtc_alarm | input | 1 | RTC alarm, active rising |
| gpio_in | input | 8 | General-purpose wake inputs, active rising |
| smi_pend | input | SMI_W | Pending SMI events, already synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| wake_pull | output | 1 | 1 = sink the wake line low; 0 = release it |

## Verification
The bench aims at the same-cycle collision between a synchronised edge and a write-one-to-clear. A design that gave priority to the clear would lose that event and read back 0. It also drives each source in its inactive direction, which catches edge detectors wired with the wrong polarity because they set bits on release. The SMI route is tested with only one of its two enable bits set and with the global enable off. Either slip would pull the line when it should stay released. Enable bit 15 is written to 1 while status bit 15 is set, to show that this bit without an enable cannot raise the request.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int N_SRC  = 15;
  localparam int ST_W   = N_SRC + 1;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_ST_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_ST_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_EN_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_EN_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;

  localparam int B_GEN   = 0;
  localparam int B_DEV   = 1;
  localparam int B_ROUTE = 2;

  // 1 where the source is idle high and active on a falling edge
  localparam logic [N_SRC-1:0] FALL_MASK = 15'h3700;
  // status bits that own an enable bit (bit 15, SMI-seen, has none)
  localparam logic [ST_W-1:0]  EN_MASK   = 16'h7FFF;

  function automatic logic wake_request(
    input logic            gen,
    input logic            dev,
    input logic            route,
    input logic [ST_W-1:0] st,
    input logic [ST_W-1:0] en,
    input logic            smi_any
  );
    logic src_hit;
    src_hit = |(st & en & EN_MASK);
    return gen & (src_hit | (dev & route & smi_any));
  endfunction

  function automatic logic [ST_W-1:0] clear_vec(
    input logic              we,
    input logic [ADDR_W-1:0] a,
    input logic [DATA_W-1:0] d
  );
    logic [ST_W-1:0] v;
    v = '0;
    if (we && a == A_ST_LO) v[DATA_W-1:0]    = d;
    if (we && a == A_ST_HI) v[ST_W-1:DATA_W] = d;
    return v;
  endfunction
endpackage

// File: rtl/wake_sync_edge.sv
module wake_sync_edge #(
  parameter int              W    = 15,
  parameter logic [W-1:0]    FALL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] active_edge
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= FALL;
      s2_q <= FALL;
      s3_q <= FALL;
    end else begin
      s1_q <= async_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    if (FALL[i]) begin : g_fall
      assign active_edge[i] = ~s2_q[i] & s3_q[i];
    end else begin : g_rise
      assign active_edge[i] = s2_q[i] & ~s3_q[i];
    end
  end
endmodule

// File: rtl/wake_status_bank.sv
module wake_status_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= set_vec | (status_q & ~clr_vec);
  end
endmodule

// File: rtl/wake_req_gen.sv
module wake_req_gen
  import wake_pkg::*;
#(
  parameter int SMI_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen,
  input  logic             dev,
  input  logic             route,
  input  logic [ST_W-1:0]  st,
  input  logic [ST_W-1:0]  en,
  input  logic [SMI_W-1:0] smi,
  output logic             pull_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_q <= 1'b0;
    else        pull_q <= wake_request(gen, dev, route, st, en, |smi);
  end
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_pkg::*;
#(
  parameter int SMI_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ri1_n,
  input  logic              ri2_n,
  input  logic              ring_n,
  input  logic              ir_valid,
  input  logic              kb_clk,
  input  logic              ms_clk,
  input  logic              rtc_alarm,
  input  logic [7:0]        gpio_in,
  input  logic [SMI_W-1:0]  smi_pend,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wake_pull
);
  logic [N_SRC-1:0] raw_src;
  logic [N_SRC-1:0] src_edge;
  logic [ST_W-1:0]  evt_set;
  logic [ST_W-1:0]  clr_mask;
  logic [ST_W-1:0]  status_q;
  logic [ST_W-1:0]  enable_q;
  logic             gen_en_q, dev_en_q, route_q;
  logic             smi_prev_q;
  logic             smi_rise;

  assign raw_src = {rtc_alarm, ms_clk, kb_clk, ir_valid, ring_n, ri2_n, ri1_n, gpio_in};

  wake_sync_edge #(.W(N_SRC), .FALL(FALL_MASK)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_src), .active_edge(src_edge)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_prev_q <= 1'b0;
    else        smi_prev_q <= |smi_pend;
  end
  assign smi_rise = (|smi_pend) & ~smi_prev_q;

  assign evt_set  = {smi_rise, src_edge};
  assign clr_mask = clear_vec(wr_en, addr, wr_data);

  wake_status_bank #(.W(ST_W)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_set), .clr_vec(clr_mask), .status_q(status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      gen_en_q <= 1'b0;
      dev_en_q <= 1'b0;
      route_q  <= 1'b0;
    end else if (wr_en) begin
      unique case (addr)
        A_EN_LO: enable_q[DATA_W-1:0]    <= wr_data & EN_MASK[DATA_W-1:0];
        A_EN_HI: enable_q[ST_W-1:DATA_W] <= wr_data & EN_MASK[ST_W-1:DATA_W];
        A_CTRL: begin
          gen_en_q <= wr_data[B_GEN];
          dev_en_q <= wr_data[B_DEV];
          route_q  <= wr_data[B_ROUTE];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_ST_LO: rd_data = status_q[DATA_W-1:0];
      A_ST_HI: rd_data = status_q[ST_W-1:DATA_W];
      A_EN_LO: rd_data = enable_q[DATA_W-1:0];
      A_EN_HI: rd_data = enable_q[ST_W-1:DATA_W];
      A_CTRL:  rd_data = {5'b0, route_q, dev_en_q, gen_en_q};
      default: rd_data = '0;
    endcase
  end

  wake_req_gen #(.SMI_W(SMI_W)) u_req (
    .clk(clk), .rst_n(rst_n), .gen(gen_en_q), .dev(dev_en_q), .route(route_q),
    .st(status_q), .en(enable_q), .smi(smi_pend), .pull_q(wake_pull)
  );
endmodule

// File: rtl/wake_evt_ctrl_chk.sv
module wake_evt_ctrl_chk
  import wake_pkg::*;
#(
  parameter int SMI_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ST_W-1:0]  status_q,
  input logic [ST_W-1:0]  enable_q,
  input logic             gen_en_q,
  input logic             dev_en_q,
  input logic             route_q,
  input logic [ST_W-1:0]  evt_set,
  input logic [ST_W-1:0]  clr_mask,
  input logic [SMI_W-1:0] smi_pend,
  input logic             wake_pull
);
  a_r1_gen_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_q |=> !wake_pull);

  a_r2_enabled_pair_pulls: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en_q && ((status_q & enable_q) != '0)) |=> wake_pull);

  a_r3_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((status_q & $past(evt_set)) == $past(evt_set)));

  a_r4_no_clear_without_one: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_q & $past(status_q) & ~$past(clr_mask)) == '0));

  a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & clr_mask) != '0) |=> ((status_q & $past(evt_set & clr_mask)) == $past(evt_set & clr_mask)));

  a_r8_route_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dev_en_q && route_q) && ((status_q & enable_q) == '0)) |=> !wake_pull);

  a_r9_no_enable_bit15: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[ST_W-1]) |-> !enable_q[ST_W-1]);
endmodule

bind wake_evt_ctrl wake_evt_ctrl_chk #(.SMI_W(SMI_W)) u_chk (.*);

// File: tb/wake_evt_ctrl_tb_top.sv
module wake_evt_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [14:0] src;
  logic [7:0] smi_pend = '0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic wake_pull;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [14:0] FALLS = 15'h3700;

  always #5 clk = ~clk;

  wake_evt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .ri1_n(src[8]), .ri2_n(src[9]), .ring_n(src[10]), .ir_valid(src[11]),
    .kb_clk(src[12]), .ms_clk(src[13]), .rtc_alarm(src[14]), .gpio_in(src[7:0]),
    .smi_pend(smi_pend), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .wake_pull(wake_pull)
  );

  typedef struct packed { logic [3:0] idx; logic [15:0] exp; } vec_t;
  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{4'd0,  16'h0001}, '{4'd7,  16'h0080}, '{4'd8,  16'h0100},
    '{4'd9,  16'h0200}, '{4'd10, 16'h0400}, '{4'd11, 16'h0800},
    '{4'd12, 16'h1000}, '{4'd13, 16'h2000}, '{4'd14, 16'h4000}};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic rd_status(output logic [15:0] s);
    logic [7:0] lo, hi;
    rd(3'd0, lo);
    rd(3'd1, hi);
    s = {hi, lo};
  endtask

  task automatic clear_all();
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'hFF);
  endtask

  task automatic pulse(input int i);
    @(negedge clk);
    src[i] = ~src[i];
    cyc(5);
    src[i] = ~src[i];
    cyc(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    logic [7:0] d;
    src = FALLS;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R7 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d);
      chk("R7 reg after reset", {8'h0, d}, 16'h0);
    end
    chk("R7 wake_pull after reset", {15'h0, wake_pull}, 16'h0);

    // R3 R6 table of sources and bit positions
    for (int v = 0; v < NV; v++) begin
      clear_all();
      pulse(int'(VT[v].idx));
      rd_status(s);
      chk("R3/R6 source bit", s, VT[v].exp);
    end

    // R4 write zero has no effect, write one clears only that bit
    clear_all();
    pulse(3); pulse(5);
    wr(3'd0, 8'h00);
    rd_status(s);
    chk("R4 write 0 keeps", s, 16'h0028);
    wr(3'd0, 8'h08);
    rd_status(s);
    chk("R4 write 1 clears", s, 16'h0020);

    // R10 inactive direction: gpio2 falling, ring_n rising
    clear_all();
    @(negedge clk); src[2] = 1'b1; src[10] = 1'b0;
    cyc(6);
    clear_all();
    @(negedge clk); src[2] = 1'b0; src[10] = 1'b1;
    cyc(6);
    rd_status(s);
    chk("R10 inactive edges ignored", s, 16'h0000);

    // R1 R2 enable gating
    clear_all();
    wr(3'd2, 8'h01);
    pulse(0);
    cyc(3);
    chk("R1 gen off no pull", {15'h0, wake_pull}, 16'h0);
    wr(3'd4, 8'h01);
    cyc(2);
    chk("R2 gen on pulls", {15'h0, wake_pull}, 16'h1);
    wr(3'd0, 8'h01);
    cyc(2);
    chk("R2 released after clear", {15'h0, wake_pull}, 16'h0);
    pulse(1);
    cyc(2);
    chk("R2 unenabled source no pull", {15'h0, wake_pull}, 16'h0);

    // R5 set wins over same-cycle clear (gpio4)
    clear_all();
    @(negedge clk); src[4] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 3'd0; wr_data = 8'h10;
    @(negedge clk); wr_en = 1'b0;
    rd_status(s);
    chk("R5 set beats clear", s, 16'h0010);
    @(negedge clk); src[4] = 1'b0;
    cyc(5);

    // R9 SMI-seen bit, no enable
    clear_all();
    wr(3'd2, 8'h00);
    wr(3'd3, 8'hFF);
    rd(3'd3, d);
    chk("R9 enable bit15 reads 0", {8'h0, d}, 16'h007F);
    @(negedge clk); smi_pend = 8'h04;
    cyc(3);
    rd_status(s);
    chk("R9 SMI-seen set", s, 16'h8000);
    cyc(2);
    chk("R9 bit15 no pull", {15'h0, wake_pull}, 16'h0);

    // R8 SMI route requires both bits
    wr(3'd4, 8'h03);
    cyc(2);
    chk("R8 dev only no pull", {15'h0, wake_pull}, 16'h0);
    wr(3'd4, 8'h05);
    cyc(2);
    chk("R8 route only no pull", {15'h0, wake_pull}, 16'h0);
    wr(3'd4, 8'h07);
    cyc(2);
    chk("R8 both pull", {15'h0, wake_pull}, 16'h1);
    wr(3'd4, 8'h06);
    cyc(2);
    chk("R1 gen off overrides SMI", {15'h0, wake_pull}, 16'h0);
    rd(3'd4, d);
    chk("R6 control readback", {8'h0, d}, 16'h0006);
    rd(3'd6, d);
    chk("R6 unused address", {8'h0, d}, 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule